// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level table held in ordinary memory. A request carries the virtual address and a flag that says whether the access is a store. The walker first fetches a directory entry, using the upper ten address bits and a root base input. It then fetches a leaf entry from the second-level table that the directory entry names, using the middle ten bits. The lower twelve bits pass straight through as the page offset.

Every table entry is one 32-bit word. Bit 0 is valid, bit 1 is writable, bit 2 is used and bit 3 is dirty. Bits 31:12 hold a frame number. In a directory entry that frame number is the base of the second-level table; only its valid bit and frame are read.

A walk can end in a translation or in a fault. A successful access marks the leaf entry as used, and a successful store also marks it dirty. That update is written back to the leaf slot in memory, and only when the entry actually changes. Faults are reported with a code and the faulting virtual address. The memory port issues one read per level and accepts a read response after any latency.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid` and `mem_req` are 0.
- R2: The directory entry is read at `root_base + 4*vaddr[31:22]`. The leaf entry is read at `{dir[31:12], 12'h000} + 4*vaddr[21:12]`.
- R3: On success, `resp_paddr` is `{leaf[31:12], vaddr[11:0]}`, `resp_fault` is 0, `resp_fault_kind` is 0 and `resp_vaddr` echoes the request address.
- R4: A directory entry with bit 0 clear gives `resp_fault`=1 with kind 1. The walk makes exactly one memory read and no write.
- R5: A leaf entry with bit 0 clear gives kind 2, and the leaf in memory is left unchanged.
- R6: A successful load whose leaf has used (bit 2) clear writes the leaf back with bit 2 set and every other bit kept.
- R7: A successful store writes the leaf back with both used (bit 2) and dirty (bit 3) set.
- R8: A store to a valid leaf with writable (bit 1) clear gives kind 3. Nothing is written to memory.
- R9: When the used and dirty bits the access would set are already set, no memory write occurs.
- R10: Each memory read is a single-cycle `mem_req` pulse with at most one read outstanding. The walker waits for `mem_rvalid` however long it takes.
- R11: While a walk is in progress, `req_ready` is 0 and `req_valid` is ignored.
- R12: Each accepted request yields exactly one `resp_valid` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_base | input | 32 | Byte address of the directory table |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_ready | output | 1 | Walker idle; a request is taken this cycle |
| mem_req | output | 1 | Memory access strobe, one cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated leaf entry for a write |
| mem_rvalid | input | 1 | Read data is valid |
| mem_rdata | input | 32 | Read data |
| resp_valid | output | 1 | Result strobe, one cycle |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_fault_kind | output | 2 | 0 none, 1 directory absent, 2 leaf absent, 3 protection |
| resp_vaddr | output | 32 | Virtual address of the finished walk |
| resp_paddr | output | 32 | Physical address (0 on a fault) |

## Verification
The hardest case to reach is a request that arrives while a walk is still running. It is hard because the memory port answers slowly, and a stray acceptance would only show up as an extra response or a wrong address. The bench stretches the read latency to several cycles. While the first walk runs, it holds `req_valid` high with a second address that would fault, and drops it on the cycle the result appears. It then checks that exactly one response came back and that it carries the first translation. The write-back rules are probed through the bench's own memory: it counts reads and writes per walk and compares leaf words before and after each walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Field positions inside a table entry
  localparam int unsigned ENT_VALID = 0;
  localparam int unsigned ENT_WRITE = 1;
  localparam int unsigned ENT_USED  = 2;
  localparam int unsigned ENT_DIRTY = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_L1,
    ST_READ_L2,
    ST_UPDATE,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE        = 2'd0,
    FLT_DIR_ABSENT  = 2'd1,
    FLT_LEAF_ABSENT = 2'd2,
    FLT_PROTECT     = 2'd3
  } fault_e;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX1_W = 10,
  parameter int unsigned IDX2_W = 10,
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned ENT_W  = 32
) (
  input  logic [ADDR_W-1:0]       root_base,
  input  logic [IDX1_W-1:0]       dir_idx,
  input  logic [ADDR_W-OFS_W-1:0] tbl_frame,
  input  logic [IDX2_W-1:0]       leaf_idx,
  output logic [ADDR_W-1:0]       dir_addr,
  output logic [ADDR_W-1:0]       leaf_addr
);
  // Byte shift turning an entry index into a byte offset
  localparam int unsigned ENT_SH = $clog2(ENT_W / 8);

  logic [ADDR_W-1:0] dir_ofs;
  logic [ADDR_W-1:0] leaf_ofs;
  logic [ADDR_W-1:0] tbl_base;

  always_comb begin
    dir_ofs   = ADDR_W'(dir_idx) << ENT_SH;
    leaf_ofs  = ADDR_W'(leaf_idx) << ENT_SH;
    tbl_base  = {tbl_frame, {OFS_W{1'b0}}};
    dir_addr  = root_base + dir_ofs;
    leaf_addr = tbl_base + leaf_ofs;
  end

endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
  import ptw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned ENT_W  = 32
) (
  input  logic [ENT_W-1:0]  leaf,
  input  logic              is_write,
  input  logic [OFS_W-1:0]  page_ofs,
  output logic [1:0]        fault,
  output logic [ENT_W-1:0]  new_leaf,
  output logic              need_wb,
  output logic [ADDR_W-1:0] paddr
);
  fault_e code;

  always_comb begin
    new_leaf            = leaf;
    new_leaf[ENT_USED]  = 1'b1;
    if (is_write) begin
      new_leaf[ENT_DIRTY] = 1'b1;
    end

    if (!leaf[ENT_VALID]) begin
      code = FLT_LEAF_ABSENT;
    end else if (is_write && !leaf[ENT_WRITE]) begin
      code = FLT_PROTECT;
    end else begin
      code = FLT_NONE;
    end

    fault   = code;
    need_wb = (code == FLT_NONE) && (new_leaf != leaf);
    paddr   = {leaf[ENT_W-1:OFS_W], page_ofs};
  end

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ENT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] dir_addr,
  input  logic [ADDR_W-1:0] leaf_addr,
  output logic [ADDR_W-1:0] vaddr_q,
  output logic              write_q,
  output logic [ENT_W-1:0]  leaf_q,
  input  logic [1:0]        ev_fault,
  input  logic [ENT_W-1:0]  ev_new_leaf,
  input  logic              ev_need_wb,
  input  logic [ADDR_W-1:0] ev_paddr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ENT_W-1:0]  mem_wdata,
  input  logic              mem_rvalid,
  input  logic [ENT_W-1:0]  mem_rdata,
  output logic              resp_valid,
  output logic              resp_fault,
  output logic [1:0]        resp_kind,
  output logic [ADDR_W-1:0] resp_vaddr,
  output logic [ADDR_W-1:0] resp_paddr
);
  walk_state_e       st;
  logic [ADDR_W-1:0] leaf_addr_q;

  assign req_ready = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      vaddr_q     <= '0;
      write_q     <= 1'b0;
      leaf_q      <= '0;
      leaf_addr_q <= '0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      resp_valid  <= 1'b0;
      resp_fault  <= 1'b0;
      resp_kind   <= FLT_NONE;
      resp_vaddr  <= '0;
      resp_paddr  <= '0;
    end else begin
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      resp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            vaddr_q  <= req_vaddr;
            write_q  <= req_write;
            mem_req  <= 1'b1;
            mem_addr <= dir_addr;
            st       <= ST_READ_L1;
          end
        end
        ST_READ_L1: begin
          if (mem_rvalid) begin
            if (!mem_rdata[ENT_VALID]) begin
              resp_valid <= 1'b1;
              resp_fault <= 1'b1;
              resp_kind  <= FLT_DIR_ABSENT;
              resp_vaddr <= vaddr_q;
              resp_paddr <= '0;
              st         <= ST_FAULT;
            end else begin
              mem_req     <= 1'b1;
              mem_addr    <= leaf_addr;
              leaf_addr_q <= leaf_addr;
              st          <= ST_READ_L2;
            end
          end
        end
        ST_READ_L2: begin
          if (mem_rvalid) begin
            leaf_q <= mem_rdata;
            st     <= ST_UPDATE;
          end
        end
        ST_UPDATE: begin
          resp_valid <= 1'b1;
          resp_vaddr <= vaddr_q;
          if (ev_fault != FLT_NONE) begin
            resp_fault <= 1'b1;
            resp_kind  <= ev_fault;
            resp_paddr <= '0;
            st         <= ST_FAULT;
          end else begin
            resp_fault <= 1'b0;
            resp_kind  <= FLT_NONE;
            resp_paddr <= ev_paddr;
            if (ev_need_wb) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= leaf_addr_q;
              mem_wdata <= ev_new_leaf;
            end
            st <= ST_DONE;
          end
        end
        ST_DONE:  st <= ST_IDLE;
        ST_FAULT: st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX1_W = 10,
  parameter int unsigned IDX2_W = 10,
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned ENT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] root_base,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  output logic              req_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ENT_W-1:0]  mem_wdata,
  input  logic              mem_rvalid,
  input  logic [ENT_W-1:0]  mem_rdata,
  output logic              resp_valid,
  output logic              resp_fault,
  output logic [1:0]        resp_fault_kind,
  output logic [ADDR_W-1:0] resp_vaddr,
  output logic [ADDR_W-1:0] resp_paddr
);
  localparam int unsigned FRAME_W = ADDR_W - OFS_W;
  localparam int unsigned IDX2_LO = OFS_W;
  localparam int unsigned IDX1_LO = OFS_W + IDX2_W;

  logic [ADDR_W-1:0] dir_addr;
  logic [ADDR_W-1:0] leaf_addr;
  logic [ADDR_W-1:0] vaddr_q;
  logic              write_q;
  logic [ENT_W-1:0]  leaf_q;
  logic [1:0]        ev_fault;
  logic [ENT_W-1:0]  ev_new_leaf;
  logic              ev_need_wb;
  logic [ADDR_W-1:0] ev_paddr;

  ptw_addr_gen #(
    .ADDR_W(ADDR_W), .IDX1_W(IDX1_W), .IDX2_W(IDX2_W),
    .OFS_W(OFS_W), .ENT_W(ENT_W)
  ) u_addr (
    .root_base (root_base),
    .dir_idx   (req_vaddr[IDX1_LO +: IDX1_W]),
    .tbl_frame (mem_rdata[ENT_W-1 -: FRAME_W]),
    .leaf_idx  (vaddr_q[IDX2_LO +: IDX2_W]),
    .dir_addr  (dir_addr),
    .leaf_addr (leaf_addr)
  );

  ptw_leaf_eval #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .ENT_W(ENT_W)
  ) u_eval (
    .leaf     (leaf_q),
    .is_write (write_q),
    .page_ofs (vaddr_q[OFS_W-1:0]),
    .fault    (ev_fault),
    .new_leaf (ev_new_leaf),
    .need_wb  (ev_need_wb),
    .paddr    (ev_paddr)
  );

  ptw_fsm #(
    .ADDR_W(ADDR_W), .ENT_W(ENT_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_vaddr   (req_vaddr),
    .req_write   (req_write),
    .req_ready   (req_ready),
    .dir_addr    (dir_addr),
    .leaf_addr   (leaf_addr),
    .vaddr_q     (vaddr_q),
    .write_q     (write_q),
    .leaf_q      (leaf_q),
    .ev_fault    (ev_fault),
    .ev_new_leaf (ev_new_leaf),
    .ev_need_wb  (ev_need_wb),
    .ev_paddr    (ev_paddr),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .resp_valid  (resp_valid),
    .resp_fault  (resp_fault),
    .resp_kind   (resp_fault_kind),
    .resp_vaddr  (resp_vaddr),
    .resp_paddr  (resp_paddr)
  );

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned ENT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ENT_W-1:0]  mem_wdata,
  input logic              mem_rvalid,
  input logic              resp_valid,
  input logic              resp_fault,
  input logic [1:0]        resp_fault_kind,
  input logic [ADDR_W-1:0] resp_vaddr,
  input logic [ADDR_W-1:0] resp_paddr
);
  logic rd_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend <= 1'b0;
    end else if (mem_req && !mem_we) begin
      rd_pend <= 1'b1;
    end else if (mem_rvalid) begin
      rd_pend <= 1'b0;
    end
  end

  a_r10_req_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> !rd_pend);

  a_r12_resp_pulse: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r6_wb_marks_used: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_wdata[0] && mem_wdata[2]));

  a_r3_offset_passthrough: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_fault) |-> (resp_paddr[OFS_W-1:0] == resp_vaddr[OFS_W-1:0]));

  a_r4_fault_has_kind: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault) |-> (resp_fault_kind != 2'd0));

endmodule

bind ptw_walker ptw_walker_chk #(
  .ADDR_W(ADDR_W), .OFS_W(OFS_W), .ENT_W(ENT_W)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .mem_req         (mem_req),
  .mem_we          (mem_we),
  .mem_wdata       (mem_wdata),
  .mem_rvalid      (mem_rvalid),
  .resp_valid      (resp_valid),
  .resp_fault      (resp_fault),
  .resp_fault_kind (resp_fault_kind),
  .resp_vaddr      (resp_vaddr),
  .resp_paddr      (resp_paddr)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] root_base = 32'h0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = 32'h0;
  logic        req_write = 1'b0;
  logic        req_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = 32'h0;
  logic        resp_valid, resp_fault;
  logic [1:0]  resp_fault_kind;
  logic [31:0] resp_vaddr, resp_paddr;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst(rst), .root_base(root_base),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
    .req_ready(req_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .resp_valid(resp_valid), .resp_fault(resp_fault),
    .resp_fault_kind(resp_fault_kind), .resp_vaddr(resp_vaddr),
    .resp_paddr(resp_paddr)
  );

  // Plain word-array memory with programmable read latency
  logic [31:0] mem [0:4095];
  int          lat = 1;
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  int          cnt = 0;
  logic [31:0] rd_addr = 32'h0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req && mem_we) begin
      mem[mem_addr[13:2]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end else if (mem_req) begin
      rd_addr <= mem_addr;
      cnt     <= lat;
      rd_cnt  <= rd_cnt + 1;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[rd_addr[13:2]];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] r_paddr, r_vaddr;
  logic        r_fault;
  logic [1:0]  r_kind;
  int          r_reads, r_writes;

  task automatic walk(input logic [31:0] va, input logic wr);
    int rd0, wr0;
    @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 200 && !resp_valid; i++) @(negedge clk);
    r_paddr = resp_paddr; r_vaddr = resp_vaddr;
    r_fault = resp_fault; r_kind = resp_fault_kind;
    @(negedge clk);
    chk("R12 resp pulse one cycle", {31'b0, resp_valid}, 32'd0);
    repeat (3) @(negedge clk);
    r_reads = rd_cnt - rd0; r_writes = wr_cnt - wr0;
  endtask

  task automatic t_reset;
    chk("R1 ready after reset", {31'b0, req_ready}, 32'd1);
    chk("R1 no resp after reset", {31'b0, resp_valid}, 32'd0);
    chk("R1 no mem req after reset", {31'b0, mem_req}, 32'd0);
  endtask

  task automatic t_load_hit;
    lat = 1;
    walk(32'h0040_3ABC, 1'b0);
    chk("R2 R3 load paddr", r_paddr, 32'hABCD_EABC);
    chk("R3 load fault flag", {31'b0, r_fault}, 32'd0);
    chk("R3 load vaddr echo", r_vaddr, 32'h0040_3ABC);
    chk("R2 load read count", r_reads, 32'd2);
    chk("R6 used write-back", mem[12'h403], 32'hABCD_E007);
    chk("R6 one write", r_writes, 32'd1);
  endtask

  task automatic t_store_hit;
    lat = 2;
    walk(32'h0040_5123, 1'b1);
    chk("R7 store paddr", r_paddr, 32'h1234_5123);
    chk("R7 used and dirty set", mem[12'h405], 32'h1234_500F);
  endtask

  task automatic t_no_writeback;
    lat = 3;
    walk(32'h0040_5FF0, 1'b1);
    chk("R10 slow memory paddr", r_paddr, 32'h1234_5FF0);
    chk("R9 no write when bits set", r_writes, 32'd0);
    walk(32'h0040_3004, 1'b0);
    chk("R9 load no write", r_writes, 32'd0);
  endtask

  task automatic t_dir_fault;
    lat = 1;
    walk(32'hFFC0_0000, 1'b0);
    chk("R4 fault flag", {31'b0, r_fault}, 32'd1);
    chk("R4 fault kind", {30'b0, r_kind}, 32'd1);
    chk("R4 fault vaddr", r_vaddr, 32'hFFC0_0000);
    chk("R4 single read", r_reads, 32'd1);
    chk("R4 no write", r_writes, 32'd0);
  endtask

  task automatic t_leaf_fault;
    lat = 2;
    walk(32'h0040_7000, 1'b1);
    chk("R5 fault kind", {30'b0, r_kind}, 32'd2);
    chk("R5 leaf unchanged", mem[12'h407], 32'h5555_5000);
    chk("R5 no write", r_writes, 32'd0);
  endtask

  task automatic t_protect;
    lat = 1;
    walk(32'h0040_8010, 1'b1);
    chk("R8 fault kind", {30'b0, r_kind}, 32'd3);
    chk("R8 no write", r_writes, 32'd0);
    chk("R8 leaf unchanged", mem[12'h408], 32'h6666_6001);
    walk(32'h0040_8010, 1'b0);
    chk("R8 load of read-only page", r_paddr, 32'h6666_6010);
    chk("R6 read-only used set", mem[12'h408], 32'h6666_6005);
  endtask

  task automatic t_other_root;
    root_base = 32'h0000_3000;
    walk(32'h0040_3ABC, 1'b0);
    chk("R2 alternate root paddr", r_paddr, 32'h7777_7ABC);
    root_base = 32'h0;
  endtask

  task automatic t_busy;
    int pulses = 0;
    logic [31:0] got = 32'h0;
    lat = 4;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0040_3ABC; req_write = 1'b0;
    @(negedge clk);
    req_vaddr = 32'hFFC0_0000;
    chk("R11 not ready while busy", {31'b0, req_ready}, 32'd0);
    for (int i = 0; i < 200 && !resp_valid; i++) @(negedge clk);
    req_valid = 1'b0;
    if (resp_valid) begin
      pulses++;
      got = resp_paddr;
    end
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (resp_valid) pulses++;
    end
    chk("R11 first request result", got, 32'hABCD_EABC);
    chk("R12 single response", pulses, 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    mem[12'h001] = 32'h0000_1001;
    mem[12'h403] = 32'hABCD_E003;
    mem[12'h405] = 32'h1234_5003;
    mem[12'h407] = 32'h5555_5000;
    mem[12'h408] = 32'h6666_6001;
    mem[12'hC01] = 32'h0000_2001;
    mem[12'h803] = 32'h7777_7007;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load_hit();
    t_store_hit();
    t_no_writeback();
    t_dir_fault();
    t_leaf_fault();
    t_protect();
    t_other_root();
    t_busy();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule